// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block follows the active-lane mask of a single 32-lane warp through conditional branches. Each branch event arrives with a per-lane taken vector and three program counters: the taken target, the fall-through address and the reconvergence address. The block looks only at the taken bits of currently active lanes. If they all agree, the warp simply follows one path and its mask is left alone. If they disagree, the warp runs the taken path first with only the taken lanes enabled. It then runs the fall-through path with only the remaining lanes enabled. When the second path reaches the reconvergence address, the pre-branch mask comes back.

Pending paths sit in a stack of frames. Each frame holds a resume PC, a mask and the reconvergence PC of its enclosing level, so divergence can nest. The current path lives in registers. A split stores two frames: first the reconvergence frame carrying the original mask, then the fall-through frame. The fetch side drives `cur_pc` with the address of the instruction being issued. Every cycle the block answers with the registered `next_pc` and `active_mask` that apply to the following instruction.

Top module: `simt_reconv_stack`

## Requirements
- R1: After synchronous reset, `next_pc` is 0, `active_mask` is all ones (0xFFFFFFFF) and `overflow` is 0.
- R2: In a cycle with no branch event and no reconvergence match, `next_pc` becomes `cur_pc + 4` one cycle later and `active_mask` is unchanged.
- R3: When the taken bits of every active lane are all 1, `next_pc` becomes `br_target`. When they are all 0, `next_pc` becomes `br_fallthru`. In both cases `active_mask` is unchanged.
- R4: When active lanes disagree, one cycle later `next_pc` is `br_target` and `active_mask` is `active_mask & br_taken`.
- R5: While a divergent path runs and `cur_pc` differs from its reconvergence PC, the mask is held. The first time `cur_pc` equals the reconvergence PC, the next cycle gives `next_pc = br_fallthru` and mask = pre-branch mask `& ~br_taken`.
- R6: The second time `cur_pc` equals the reconvergence PC, the next cycle gives `next_pc` = the reconvergence PC and the full pre-branch mask. A further cycle at the same PC does not pop again; it yields `cur_pc + 4`.
- R7: Taken bits of inactive lanes have no effect. Nested divergence inside a path restores each enclosing level's mask in order.
- R8: A split needs two free frames; with DEPTH=8 at most four splits can be nested. A split attempted without room sets `overflow`, which stays 1 until reset. The branch itself is then dropped: `next_pc = cur_pc + 4` and the mask is unchanged.
- R9: When `cur_pc` matches the reconvergence PC in the same cycle as a branch event, the reconvergence action is taken and the branch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch event is present this cycle |
| br_taken | input | 32 | Per-lane branch outcome, 1 = taken |
| br_target | input | 32 | PC of the taken path |
| br_fallthru | input | 32 | PC of the not-taken path |
| br_reconv | input | 32 | PC where the two paths rejoin |
| cur_pc | input | 32 | PC of the instruction issued this cycle |
| next_pc | output | 32 | PC to issue next (registered) |
| active_mask | output | 32 | Lanes enabled for the next instruction (registered) |
| overflow | output | 1 | Sticky flag: a split found no room in the stack |

## Verification
Every result sits in an output register, so each stimulus applied during one cycle is due on `next_pc`, `active_mask` and `overflow` right after the following rising edge. The bench changes inputs on the falling edge and compares outputs at the next falling edge, exactly one register stage later. A pop therefore appears one cycle after `cur_pc` meets the reconvergence PC, and a restore after a second match appears one cycle after that. The sweep splits the warp on every single lane, and expected PCs and masks are derived from the shift position.

// File: rtl/simt_pkg.sv
package simt_pkg;

    parameter int unsigned LANES = 32;
    parameter int unsigned PC_W  = 32;

    typedef logic [LANES-1:0] mask_t;
    typedef logic [PC_W-1:0]  pc_t;

    // One pending path: where to resume, with which lanes, and where it ends.
    typedef struct packed {
        pc_t   rpc;
        logic  rpc_vld;
        pc_t   npc;
        mask_t mask;
    } frame_t;

    typedef enum logic [1:0] {
        BR_NONE  = 2'd0,
        BR_ALL_T = 2'd1,
        BR_ALL_N = 2'd2,
        BR_SPLIT = 2'd3
    } br_kind_e;

    function automatic br_kind_e classify(logic vld, mask_t act, mask_t tk);
        mask_t eff;
        eff = act & tk;
        if (!vld || act == '0) return BR_NONE;
        if (eff == act)        return BR_ALL_T;
        if (eff == '0)         return BR_ALL_N;
        return BR_SPLIT;
    endfunction

endpackage

// File: rtl/simt_br_classify.sv
module simt_br_classify
    import simt_pkg::*;
(
    input  logic     br_valid,
    input  mask_t    act_mask,
    input  mask_t    br_taken,
    output br_kind_e kind,
    output mask_t    tk_mask,
    output mask_t    nt_mask
);

    always_comb begin
        kind    = classify(br_valid, act_mask, br_taken);
        tk_mask = act_mask & br_taken;
        nt_mask = act_mask & ~br_taken;
    end

    // R7: a split always leaves both halves populated with active lanes only
    always_comb begin
        if (kind == BR_SPLIT) begin
            a_split_halves_r7: assert (tk_mask != '0 && nt_mask != '0 && (tk_mask | nt_mask) == act_mask);
        end
    end

endmodule

// File: rtl/simt_frame_stack.sv
module simt_frame_stack
    import simt_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push2,
    input  frame_t push_lo,
    input  frame_t push_hi,
    input  logic   pop,
    output frame_t top,
    output logic   room2
);

    logic [CW-1:0] cnt_q;
    frame_t        slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        frame_t slot_q;
        always_ff @(posedge clk) begin
            if (push2 && int'(cnt_q) == g) begin
                slot_q <= push_lo;
            end else if (push2 && int'(cnt_q) + 1 == g) begin
                slot_q <= push_hi;
            end
        end
        assign slots[g] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push2) begin
            cnt_q <= cnt_q + CW'(2);
        end else if (pop) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        room2 = (int'(cnt_q) + 2) <= int'(DEPTH);
        top   = (cnt_q == '0) ? '0 : slots[AW'(cnt_q - CW'(1))];
    end

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt_q != '0);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        push2 |-> int'(cnt_q) + 2 <= int'(DEPTH));
    p_one_op_r9: assert property (@(posedge clk) disable iff (rst)
        !(push2 && pop));
    p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= int'(DEPTH));

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic [PC_W-1:0]  cur_pc,
    output logic [PC_W-1:0]  next_pc,
    output logic [LANES-1:0] active_mask,
    output logic             overflow
);

    localparam pc_t STEP = PC_W'(INSN_BYTES);

    pc_t      next_pc_q;
    mask_t    mask_q;
    pc_t      rpc_q;
    logic     rpc_vld_q;
    logic     ovf_q;

    br_kind_e kind;
    mask_t    tk_mask;
    mask_t    nt_mask;
    frame_t   top;
    frame_t   push_lo;
    frame_t   push_hi;
    logic     room2;
    logic     pop_hit;
    logic     do_split;

    simt_br_classify u_cls (
        .br_valid (br_valid),
        .act_mask (mask_q),
        .br_taken (br_taken),
        .kind     (kind),
        .tk_mask  (tk_mask),
        .nt_mask  (nt_mask)
    );

    always_comb begin
        pop_hit  = rpc_vld_q && (cur_pc == rpc_q);
        do_split = !pop_hit && (kind == BR_SPLIT) && room2;
        push_lo  = '{rpc: rpc_q, rpc_vld: rpc_vld_q, npc: br_reconv, mask: mask_q};
        push_hi  = '{rpc: br_reconv, rpc_vld: 1'b1, npc: br_fallthru, mask: nt_mask};
    end

    simt_frame_stack #(.DEPTH(DEPTH)) u_stk (
        .clk     (clk),
        .rst     (rst),
        .push2   (do_split),
        .push_lo (push_lo),
        .push_hi (push_hi),
        .pop     (pop_hit),
        .top     (top),
        .room2   (room2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_q <= '0;
            mask_q    <= '1;
            rpc_q     <= '0;
            rpc_vld_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else if (pop_hit) begin
            next_pc_q <= top.npc;
            mask_q    <= top.mask;
            rpc_q     <= top.rpc;
            rpc_vld_q <= top.rpc_vld;
        end else begin
            unique case (kind)
                BR_ALL_T: next_pc_q <= br_target;
                BR_ALL_N: next_pc_q <= br_fallthru;
                BR_SPLIT: begin
                    if (room2) begin
                        next_pc_q <= br_target;
                        mask_q    <= tk_mask;
                        rpc_q     <= br_reconv;
                        rpc_vld_q <= 1'b1;
                    end else begin
                        next_pc_q <= cur_pc + STEP;
                        ovf_q     <= 1'b1;
                    end
                end
                default:  next_pc_q <= cur_pc + STEP;
            endcase
        end
    end

    assign next_pc     = next_pc_q;
    assign active_mask = mask_q;
    assign overflow    = ovf_q;

    p_mask_live_r4: assert property (@(posedge clk) disable iff (rst)
        mask_q != '0);
    p_uniform_keeps_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (!pop_hit && (kind == BR_ALL_T || kind == BR_ALL_N)) |=> mask_q == $past(mask_q));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    p_split_subset_r4: assert property (@(posedge clk) disable iff (rst)
        do_split |=> (mask_q & ~$past(mask_q)) == '0);
    p_base_level_r6: assert property (@(posedge clk) disable iff (rst)
        !rpc_vld_q |-> mask_q == '1);

endmodule

// File: tb/simt_reconv_stack_tb_top.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 1'b0;
    logic [31:0] br_taken = '0;
    logic [31:0] br_target = '0;
    logic [31:0] br_fallthru = '0;
    logic [31:0] br_reconv = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] next_pc;
    logic [31:0] active_mask;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    simt_reconv_stack dut_i (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
        .br_target(br_target), .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .cur_pc(cur_pc), .next_pc(next_pc), .active_mask(active_mask),
        .overflow(overflow)
    );

    task automatic chk(string req, logic [31:0] e_pc, logic [31:0] e_m, logic e_o);
        checks++;
        if (next_pc !== e_pc || active_mask !== e_m || overflow !== e_o) begin
            errors++;
            $display("FAIL %s: pc=%h mask=%h ovf=%b expected pc=%h mask=%h ovf=%b",
                     req, next_pc, active_mask, overflow, e_pc, e_m, e_o);
        end
    endtask

    // Called at a falling edge: apply inputs, wait one cycle, return at next falling edge.
    task automatic step(logic v, logic [31:0] tk, logic [31:0] t, logic [31:0] f,
                        logic [31:0] r, logic [31:0] pc);
        br_valid = v; br_taken = tk; br_target = t; br_fallthru = f;
        br_reconv = r; cur_pc = pc;
        @(negedge clk);
    endtask

    task automatic idle(logic [31:0] pc);
        step(1'b0, '0, '0, '0, '0, pc);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(32'h0);
        idle(32'h0);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset", 32'h0, 32'hFFFF_FFFF, 1'b0);

        idle(32'h10);
        chk("R2 sequential", 32'h14, 32'hFFFF_FFFF, 1'b0);

        step(1'b1, 32'hFFFF_FFFF, 32'h100, 32'h200, 32'h300, 32'h20);
        chk("R3 uniform taken", 32'h100, 32'hFFFF_FFFF, 1'b0);
        step(1'b1, 32'h0, 32'h100, 32'h200, 32'h300, 32'h100);
        chk("R3 uniform not taken", 32'h200, 32'hFFFF_FFFF, 1'b0);

        // Split on each single lane
        for (int i = 0; i < 32; i++) begin
            logic [31:0] one;
            one = 32'h1 << i;
            step(1'b1, one, 32'h100, 32'h200, 32'h300, 32'h40);
            chk("R4 split", 32'h100, one, 1'b0);
            idle(32'h104);
            chk("R5 path hold", 32'h108, one, 1'b0);
            idle(32'h300);
            chk("R5 switch to fallthru", 32'h200, ~one, 1'b0);
            idle(32'h300);
            chk("R6 restore", 32'h300, 32'hFFFF_FFFF, 1'b0);
            idle(32'h300);
            chk("R6 no second pop", 32'h304, 32'hFFFF_FFFF, 1'b0);
        end

        // Nested divergence, inactive taken bits set
        step(1'b1, 32'h0000_FFFF, 32'h100, 32'h200, 32'h300, 32'h40);
        chk("R4 outer split", 32'h100, 32'h0000_FFFF, 1'b0);
        step(1'b1, 32'hFF00_00FF, 32'h150, 32'h180, 32'h1A0, 32'h104);
        chk("R7 inner split masked", 32'h150, 32'h0000_00FF, 1'b0);
        idle(32'h154);
        chk("R7 inner hold", 32'h158, 32'h0000_00FF, 1'b0);
        idle(32'h1A0);
        chk("R7 inner fallthru", 32'h180, 32'h0000_FF00, 1'b0);
        idle(32'h1A0);
        chk("R7 inner restore", 32'h1A0, 32'h0000_FFFF, 1'b0);
        idle(32'h1A0);
        chk("R7 no pop at inner pc", 32'h1A4, 32'h0000_FFFF, 1'b0);
        step(1'b1, 32'hFFFF_0000, 32'h500, 32'h1A8, 32'h600, 32'h1A4);
        chk("R7 inactive bits uniform", 32'h1A8, 32'h0000_FFFF, 1'b0);
        idle(32'h300);
        chk("R7 outer fallthru", 32'h200, 32'hFFFF_0000, 1'b0);
        idle(32'h300);
        chk("R7 outer restore", 32'h300, 32'hFFFF_FFFF, 1'b0);

        // Reconvergence beats a branch in the same cycle
        step(1'b1, 32'h0000_000F, 32'h100, 32'h200, 32'h300, 32'h40);
        chk("R9 setup split", 32'h100, 32'h0000_000F, 1'b0);
        step(1'b1, 32'hFFFF_FFFF, 32'h900, 32'hA00, 32'hB00, 32'h300);
        chk("R9 pop wins", 32'h200, 32'hFFFF_FFF0, 1'b0);
        step(1'b1, 32'h0, 32'h900, 32'hA00, 32'hB00, 32'h300);
        chk("R9 restore wins", 32'h300, 32'hFFFF_FFFF, 1'b0);

        // Overflow: four nested splits fill eight frames
        for (int k = 1; k <= 4; k++) begin
            logic [31:0] tk;
            tk = ~((32'h1 << k) - 32'h1);
            step(1'b1, tk, 32'h1000 * k, 32'h1000 * k + 32'h80, 32'h1000 * k + 32'hF0,
                 32'h1000 * (k - 1) + 32'h10);
            chk("R8 nest within depth", 32'h1000 * k, tk, 1'b0);
        end
        step(1'b1, 32'hFFFF_FFE0, 32'h5000, 32'h5080, 32'h50F0, 32'h4010);
        chk("R8 overflow drop", 32'h4014, 32'hFFFF_FFF0, 1'b1);
        idle(32'h40F0);
        chk("R8 unwind after overflow", 32'h4080, 32'h0000_0008, 1'b1);
        idle(32'h4084);
        chk("R8 sticky", 32'h4088, 32'h0000_0008, 1'b1);
        do_reset();
        chk("R8 cleared by reset", 32'h0, 32'hFFFF_FFFF, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule